// File: doc/BRIEF.md
# Board System Register File

This block is a word-addressed 32-bit register file that gathers the small control and status functions of a development board in one place. Software reads fixed identity words holding 12-bit board codes for the motherboard and for both daughterboard sites. It drives eight user LEDs and the active-low flash write-protect line. It samples card status, user switch and master-site strap pins, and it keeps two free-running timestamp counters that advance on external tick enables.

Two flag banks are written with set/clear semantics, so several agents can change individual bits without a read-modify-write. Writing a bank's primary word ORs the data into it. Writing the following word clears every bit that is 1 in the data. The volatile bank is wiped by a soft reset, and the persistent bank keeps its contents until a hard reset. Read data is registered and appears one cycle after the read strobe.

Top module: `board_sysregs`

## Requirements
- R1: A hard reset (`rst` high at a clock edge) sets the LED register, both flag banks, the flash control register and `bus_rdata` to 0. As a result, `led_out` is 0 and `flash_wp_n` is 0.
- R2: Word 0 (byte 0x000) reads `MB_CODE` in bits 27:16 and 0 elsewhere. Word 33 (byte 0x084) reads `DB1_CODE` in bits 11:0 and 0 elsewhere. Word 34 (byte 0x088) reads `DB2_CODE` in bits 11:0 and 0 elsewhere. Writes to these words have no effect.
- R3: A write to word 2 (byte 0x008) stores bits 7:0 and drives them onto `led_out` one cycle later. The word reads back those 8 bits, with 0 above them. Writing 0 turns every LED off.
- R4: Word 12 (byte 0x030) reads the volatile flags. A write to word 12 ORs the data into the flags. A write to word 13 (byte 0x034) clears each flag bit that is 1 in the data. Word 13 reads as 0.
- R5: The persistent flags follow the same scheme: read and set at word 14 (byte 0x038), clear at word 15 (byte 0x03C). Word 15 reads as 0.
- R6: A `soft_rst` pulse clears the volatile flags. It leaves the persistent flags, the LED register and the flash control register unchanged.
- R7: Word 18 (byte 0x048) reads `card_det` in bit 0 and `card_wp` in bit 1, through a two-stage synchronizer. Writes to word 18 have no effect.
- R8: Bit 0 of word 19 (byte 0x04C) is writable and read back, and it drives `flash_wp_n` directly. A 0 asserts write protection.
- R9: Word 24 (byte 0x060) reads the synchronized `master_sel` strap in bit 14 and 0 elsewhere. A 1 selects the second daughterboard site.
- R10: Word 9 (byte 0x024) and word 23 (byte 0x05C) read `CNT_W`-bit up-counters, zero-extended. Each counter advances by one on every clock where `tick_slow` or `tick_fast` respectively is high. Each wraps from all-ones to 0, and writes to them are ignored.
- R11: Word 1 (byte 0x004) reads the synchronized `user_sw` pins in bits 7:0. Every offset without a register reads 0, and writes to such offsets change nothing.
- R12: `bus_rdata` takes the addressed value on the clock edge where `bus_rd` is high. It holds that value while `bus_rd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset, clears volatile flags only |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| user_sw | input | 8 | User switch pins |
| card_det | input | 1 | Card present pin |
| card_wp | input | 1 | Card write-protect pin |
| master_sel | input | 1 | Master-site strap |
| tick_slow | input | 1 | Tick enable of the slow counter |
| tick_fast | input | 1 | Tick enable of the fast counter |
| led_out | output | 8 | User LED drive |
| flash_wp_n | output | 1 | Flash write-protect, active low |

## Verification
A flag bank holding a wrong bit shows it on the next read of its primary word: one cycle after the read strobe, with no other path to the ports. A corrupted LED or flash control bit appears on `led_out` or `flash_wp_n` one cycle after the write that set it. A counter that misses or doubles a tick is seen only when the counter is read, so directed tick bursts with a known count are compared against the expected value taken modulo 2^CNT_W. The soft reset is checked by reading both banks right after the pulse.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int LED_W     = 8;
  localparam int SW_W      = 8;
  localparam int CODE_W    = 12;
  localparam int ID_LSB    = 16;
  localparam int MASTER_BIT = 14;
  // word addresses (byte offset / 4)
  localparam int A_ID      = 0;
  localparam int A_SW      = 1;
  localparam int A_LED     = 2;
  localparam int A_SLOW    = 9;
  localparam int A_FL_SET  = 12;
  localparam int A_FL_CLR  = 13;
  localparam int A_NV_SET  = 14;
  localparam int A_NV_CLR  = 15;
  localparam int A_CARD    = 18;
  localparam int A_FLASH   = 19;
  localparam int A_FAST    = 23;
  localparam int A_MISC    = 24;
  localparam int A_PID0    = 33;
  localparam int A_PID1    = 34;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bsr_setclr_bank.sv
module bsr_setclr_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst || soft_clr) val <= '0;
    else if (set_en)     val <= val | wdata;
    else if (clr_en)     val <= val & ~wdata;
  end

  // R6
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> val == '0);

  // R4
  set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !soft_clr) |=> (val & $past(val)) == $past(val));

  // R5
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en && !soft_clr) |=> (val & $past(wdata)) == '0);
endmodule

// File: rtl/bsr_tick_counter.sv
module bsr_tick_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + 1'b1);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/board_sysregs.sv
module board_sysregs
  import board_regs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 32,
  parameter logic [CODE_W-1:0] MB_CODE  = 12'h190,
  parameter logic [CODE_W-1:0] DB1_CODE = 12'h237,
  parameter logic [CODE_W-1:0] DB2_CODE = 12'h249
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   user_sw,
  input  logic              card_det,
  input  logic              card_wp,
  input  logic              master_sel,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic [LED_W-1:0]  led_out,
  output logic              flash_wp_n
);
  localparam int PIN_W = SW_W + 3;

  logic [PIN_W-1:0]  pins_s;
  logic [SW_W-1:0]   sw_s;
  logic              det_s, wp_s, master_s;
  logic [DATA_W-1:0] flags, nvflags, rd_mux;
  logic [CNT_W-1:0]  cnt_slow, cnt_fast;

  bsr_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .d({user_sw, card_det, card_wp, master_sel}),
    .q(pins_s)
  );
  assign {sw_s, det_s, wp_s, master_s} = pins_s;

  bsr_setclr_bank #(.W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .soft_clr(soft_rst),
    .set_en(bus_wr && bus_addr == ADDR_W'(A_FL_SET)),
    .clr_en(bus_wr && bus_addr == ADDR_W'(A_FL_CLR)),
    .wdata(bus_wdata), .val(flags)
  );

  bsr_setclr_bank #(.W(DATA_W)) u_nvflags (
    .clk(clk), .rst(rst), .soft_clr(1'b0),
    .set_en(bus_wr && bus_addr == ADDR_W'(A_NV_SET)),
    .clr_en(bus_wr && bus_addr == ADDR_W'(A_NV_CLR)),
    .wdata(bus_wdata), .val(nvflags)
  );

  bsr_tick_counter #(.W(CNT_W)) u_cnt_slow (
    .clk(clk), .rst(rst), .tick(tick_slow), .cnt(cnt_slow)
  );
  bsr_tick_counter #(.W(CNT_W)) u_cnt_fast (
    .clk(clk), .rst(rst), .tick(tick_fast), .cnt(cnt_fast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_out    <= '0;
      flash_wp_n <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_LED))   led_out    <= bus_wdata[LED_W-1:0];
      if (bus_addr == ADDR_W'(A_FLASH)) flash_wp_n <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_ID):     rd_mux[ID_LSB +: CODE_W] = MB_CODE;
      ADDR_W'(A_SW):     rd_mux[SW_W-1:0] = sw_s;
      ADDR_W'(A_LED):    rd_mux[LED_W-1:0] = led_out;
      ADDR_W'(A_SLOW):   rd_mux = DATA_W'(cnt_slow);
      ADDR_W'(A_FL_SET): rd_mux = flags;
      ADDR_W'(A_NV_SET): rd_mux = nvflags;
      ADDR_W'(A_CARD):   rd_mux[1:0] = {wp_s, det_s};
      ADDR_W'(A_FLASH):  rd_mux[0] = flash_wp_n;
      ADDR_W'(A_FAST):   rd_mux = DATA_W'(cnt_fast);
      ADDR_W'(A_MISC):   rd_mux[MASTER_BIT] = master_s;
      ADDR_W'(A_PID0):   rd_mux[CODE_W-1:0] = DB1_CODE;
      ADDR_W'(A_PID1):   rd_mux[CODE_W-1:0] = DB2_CODE;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R3
  led_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_LED)) |=> led_out == $past(bus_wdata[LED_W-1:0]));

  // R3
  led_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(led_out));

  // R8
  flash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(A_FLASH)) |=> $stable(flash_wp_n));
endmodule

// File: tb/test_board_sysregs.sv
module test_board_sysregs;
  localparam int AW = 6;
  localparam int CW = 8;
  localparam logic [11:0] MBC = 12'hA5C, D1C = 12'h3B1, D2C = 12'h7E2;

  logic clk = 0, rst = 1, soft_rst = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] user_sw = '0, led_out;
  logic card_det = 0, card_wp = 0, master_sel = 0;
  logic tick_slow = 0, tick_fast = 0, flash_wp_n;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_fl = 0, m_nv = 0, m_led = 0, rd;

  always #4 clk = ~clk;

  board_sysregs #(.ADDR_W(AW), .CNT_W(CW), .MB_CODE(MBC), .DB1_CODE(D1C), .DB2_CODE(D2C))
  i_board_sysregs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .user_sw(user_sw),
    .card_det(card_det), .card_wp(card_wp), .master_sel(master_sel),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .led_out(led_out), .flash_wp_n(flash_wp_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdw(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic ticks(bit fast, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_fast = 1; else tick_slow = 1;
    end
    @(negedge clk); tick_fast = 0; tick_slow = 0;
  endtask

  function automatic logic [31:0] id_word(logic [11:0] c);
    return {4'h0, c, 16'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 led", {24'h0, led_out}, 0);
    check("R1 wp_n", {31'h0, flash_wp_n}, 0);
    check("R1 rdata", bus_rdata, 0);
    rdw(12, rd); check("R1 flags", rd, 0);
    rdw(14, rd); check("R1 nvflags", rd, 0);
    // R2 identity
    rdw(0, rd);  check("R2 id", rd, id_word(MBC));
    rdw(33, rd); check("R2 pid0", rd, {20'h0, D1C});
    rdw(34, rd); check("R2 pid1", rd, {20'h0, D2C});
    wr(0, 32'hFFFF_FFFF); rdw(0, rd); check("R2 id write ignored", rd, id_word(MBC));
    // R3 LED
    wr(2, 32'hDEAD_BE5A);
    check("R3 led pins", {24'h0, led_out}, 32'h5A);
    rdw(2, rd); check("R3 led read", rd, 32'h5A);
    wr(2, 0); check("R3 led off", {24'h0, led_out}, 0);
    // R4 flags set/clear
    wr(12, 32'h0000_00F0); wr(12, 32'h8000_0001);
    rdw(12, rd); check("R4 set or", rd, 32'h8000_00F1);
    wr(13, 32'h8000_0030); rdw(12, rd); check("R4 clear", rd, 32'h0000_00C1);
    rdw(13, rd); check("R4 clear word reads 0", rd, 0);
    m_fl = 32'hC1;
    // R5 nv flags
    wr(14, 32'h1234_5678); wr(15, 32'h0000_0078);
    rdw(14, rd); check("R5 nv set/clear", rd, 32'h1234_5600);
    rdw(15, rd); check("R5 nv clear word reads 0", rd, 0);
    m_nv = 32'h1234_5600;
    // R8 flash
    wr(19, 32'hFFFF_FFFF);
    check("R8 wp_n high", {31'h0, flash_wp_n}, 1);
    rdw(19, rd); check("R8 flash read", rd, 1);
    // R6 soft reset
    wr(2, 32'h3C);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    rdw(12, rd); check("R6 flags cleared", rd, 0);
    rdw(14, rd); check("R6 nv kept", rd, m_nv);
    check("R6 led kept", {24'h0, led_out}, 32'h3C);
    check("R6 wp_n kept", {31'h0, flash_wp_n}, 1);
    m_fl = 0; m_led = 32'h3C;
    wr(19, 0); check("R8 wp_n low", {31'h0, flash_wp_n}, 0);
    // R7 card pins
    card_det = 1; card_wp = 0; repeat (3) @(negedge clk);
    rdw(18, rd); check("R7 card det", rd, 1);
    card_det = 0; card_wp = 1; repeat (3) @(negedge clk);
    rdw(18, rd); check("R7 card wp", rd, 2);
    wr(18, 32'h3); rdw(18, rd); check("R7 write ignored", rd, 2);
    // R9 strap
    master_sel = 1; repeat (3) @(negedge clk);
    rdw(24, rd); check("R9 master second site", rd, 32'h4000);
    master_sel = 0; repeat (3) @(negedge clk);
    rdw(24, rd); check("R9 master first site", rd, 0);
    // R11 switches and holes
    user_sw = 8'hA7; repeat (3) @(negedge clk);
    rdw(1, rd); check("R11 switches", rd, 32'hA7);
    wr(5, 32'hFFFF_FFFF); rdw(5, rd); check("R11 hole reads 0", rd, 0);
    rdw(12, rd); check("R11 hole write harmless", rd, m_fl);
    rdw(63, rd); check("R11 top hole reads 0", rd, 0);
    // R10 counters
    rdw(9, rd); check("R10 slow idle", rd, 0);
    ticks(0, 5); rdw(9, rd); check("R10 slow count", rd, 5);
    ticks(0, 255); rdw(9, rd); check("R10 slow wrap", rd, 4);
    ticks(1, 300); rdw(23, rd); check("R10 fast wrap", rd, 300 % 256);
    wr(23, 32'h55); rdw(23, rd); check("R10 fast write ignored", rd, 300 % 256);
    // R12 hold
    rdw(2, rd); repeat (4) @(negedge clk);
    check("R12 rdata held", bus_rdata, m_led);
    // random mix
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 300; k++) begin
      automatic logic [31:0] d = $urandom;
      case ($urandom % 7)
        0: begin wr(12, d); m_fl |= d; end
        1: begin wr(13, d); m_fl &= ~d; end
        2: begin wr(14, d); m_nv |= d; end
        3: begin wr(15, d); m_nv &= ~d; end
        4: begin wr(2, d); m_led = {24'h0, d[7:0]};
                 check("R3 random led", {24'h0, led_out}, m_led); end
        5: begin rdw(12, rd); check("R4 random flags", rd, m_fl); end
        default: begin rdw(14, rd); check("R5 random nv", rd, m_nv); end
      endcase
    end
    // R1 hard reset clears nv
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rdw(14, rd); check("R1 nv after hard reset", rd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule